// File: doc/BRIEF.md
# Dual-Channel Third-Order CIC Decimator with Result Packing

This block takes two independent streams of signed 10-bit converter samples. Each stream has its own third-order cascaded integrator-comb decimator. The decimation ratio is a power of two chosen by a shared configuration field. Each decimated result is scaled and rounded to a signed 16-bit value.

Results go into two 32-entry FIFOs, each 32 bits wide. In split mode each channel fills its own FIFO. In vector mode a result from each channel is paired into one 32-bit word, and that word is written to FIFO 0 only.

A consumer drains each FIFO with a request/acknowledge handshake. A programmable fill threshold raises a per-FIFO interrupt level. Any change of the configuration flushes the filters, the pairing state and both FIFOs.

Top module: `dual_cic_packer`

## Requirements
- R1: Each channel's result equals the input filtered by the response ((1 - z^-R)/(1 - z^-1))^3, where R = 2^cfg_log2r. It is produced on every R-th accepted sample counted from the last flush, using that sample and the ones before it. Samples before the flush count as zero.
- R2: The exact filter output y is multiplied by 2^(3·(4 - s)), where s is the effective log2 ratio. 32 is added, the sum is shifted right arithmetically by 6, and the low 16 bits form the result. Full-scale inputs of +511 and -512 give 32704 and -32768.
- R3: A cfg_log2r value above 4 acts as 4, that is, a ratio of 16.
- R4: In split mode (cfg_vector = 0), a channel-0 result is written to FIFO 0 and a channel-1 result to FIFO 1. The write happens in the cycle after the result, and the 16-bit value is sign-extended to 32 bits.
- R5: In vector mode (cfg_vector = 1), a word is written to FIFO 0 with channel 0 in bits 15:0 and channel 1 in bits 31:16. FIFO 1 receives nothing.
- R6: In vector mode, a channel's result waits until the other channel has one too, and only the newest waiting result of a channel is kept. A word is written in the cycle after both channels hold a result. Results that arrive for both channels in the same cycle pair at once.
- R7: Each FIFO holds 32 words. A write to a FIFO that is full at the clock edge is dropped.
- R8: fN_dma_req is high while FIFO N is non-empty, and fN_rdata shows the oldest word. fN_dma_ack while the request is high removes that word at the clock edge. An acknowledge while the FIFO is empty has no effect.
- R9: fN_irq is high when wm_level is non-zero and FIFO N holds at least wm_level words.
- R10: A change of cfg_log2r or cfg_vector empties both FIFOs, clears the filters and the pairing state, and discards the samples of that cycle.
- R11: After reset both requests and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_log2r | input | 3 | log2 of the decimation ratio |
| cfg_vector | input | 1 | 1 = vector (paired) storage, 0 = split |
| wm_level | input | 6 | Interrupt fill threshold, 0 disables |
| ch0_valid | input | 1 | Channel 0 sample strobe |
| ch0_data | input | 10 | Channel 0 signed sample |
| ch1_valid | input | 1 | Channel 1 sample strobe |
| ch1_data | input | 10 | Channel 1 signed sample |
| f0_dma_req | output | 1 | FIFO 0 has data |
| f0_dma_ack | input | 1 | FIFO 0 pop |
| f0_rdata | output | 32 | FIFO 0 oldest word |
| f0_irq | output | 1 | FIFO 0 watermark reached |
| f1_dma_req | output | 1 | FIFO 1 has data |
| f1_dma_ack | input | 1 | FIFO 1 pop |
| f1_rdata | output | 32 | FIFO 1 oldest word |
| f1_irq | output | 1 | FIFO 1 watermark reached |

## Verification
A corrupted integrator or comb delay shows up as a wrong FIFO word at the next decimation instant. It persists in later words, because integrator state never decays. A wrong phase count moves writes to the wrong cycle, and the per-cycle compare of the request and the head word catches that one cycle after the decimation edge. Pairing or pointer faults show as swapped halves, words missing from FIFO 0 or words appearing in FIFO 1, or a wrong interrupt level as soon as the fill count diverges.

// File: rtl/cicpack_pkg.sv
package cicpack_pkg;
  localparam int SMP_W      = 10;
  localparam int RES_W      = 16;
  localparam int MAX_LOG2R  = 4;
  localparam int FIFO_DEPTH = 32;
  localparam int ACC_W      = SMP_W + 3 * MAX_LOG2R;
  localparam int WORD_W     = 2 * RES_W;
  localparam int CFG_W      = $clog2(MAX_LOG2R + 1);
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1);

  typedef enum logic {STORE_SPLIT = 1'b0, STORE_VECTOR = 1'b1} store_mode_e;
endpackage

// File: rtl/cic3_decim.sv
module cic3_decim #(
  parameter int SMP_W     = 10,
  parameter int RES_W     = 16,
  parameter int MAX_LOG2R = 4,
  parameter int CFG_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CFG_W-1:0] log2r,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  output logic             res_valid,
  output logic [RES_W-1:0] res_data
);
  localparam int ACC_W = SMP_W + 3 * MAX_LOG2R;
  localparam int DROP  = ACC_W - RES_W;
  localparam int PH_W  = (MAX_LOG2R > 0) ? MAX_LOG2R : 1;

  // Align a filter output to full scale and round to the result width.
  function automatic logic [RES_W-1:0] scale_round(input logic [ACC_W-1:0] y,
                                                    input logic [CFG_W-1:0] s);
    logic [ACC_W-1:0] al;
    logic [ACC_W-1:0] sum;
    al  = y << (3 * (MAX_LOG2R - int'(s)));
    sum = al + ACC_W'(1 << (DROP - 1));
    return sum[ACC_W-1 -: RES_W];
  endfunction

  logic [CFG_W-1:0] eff;
  logic [PH_W-1:0]  phase, ph_end;
  logic [ACC_W-1:0] smp_ext;
  logic [ACC_W-1:0] i1, i2, i3, i1n, i2n, i3n;
  logic [ACC_W-1:0] d1, d2, d3, c1, c2, c3;
  logic             dec_tick;

  assign eff      = (log2r > CFG_W'(MAX_LOG2R)) ? CFG_W'(MAX_LOG2R) : log2r;
  assign ph_end   = PH_W'((32'd1 << eff) - 32'd1);
  assign smp_ext  = {{(ACC_W-SMP_W){smp_data[SMP_W-1]}}, smp_data};
  assign i1n      = i1 + smp_ext;
  assign i2n      = i2 + i1n;
  assign i3n      = i3 + i2n;
  assign c1       = i3n - d1;
  assign c2       = c1 - d2;
  assign c3       = c2 - d3;
  assign dec_tick = smp_valid && (phase == ph_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {i1, i2, i3, d1, d2, d3} <= '0;
      phase     <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (clr) begin
      {i1, i2, i3, d1, d2, d3} <= '0;
      phase     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= dec_tick;
      if (smp_valid) begin
        i1    <= i1n;
        i2    <= i2n;
        i3    <= i3n;
        phase <= dec_tick ? '0 : phase + 1'b1;
      end
      if (dec_tick) begin
        d1       <= i3n;
        d2       <= c1;
        d3       <= c2;
        res_data <= scale_round(c3, eff);
      end
    end
  end

  AST_RESULT_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(smp_valid)); // R1
  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n || clr)
    phase <= ph_end); // R3
endmodule

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          ack,
  input  logic [$clog2(DEPTH+1)-1:0] wm,
  output logic          req,
  output logic [W-1:0]  rd_data,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign push_ok = push && (cnt != LW'(DEPTH));
  assign pop_ok  = ack && (cnt != '0);
  assign req     = (cnt != '0);
  assign rd_data = mem[rd_ptr];
  assign irq     = (wm != '0) && (cnt >= wm);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (push && cnt == LW'(DEPTH) && !pop_ok) |=> $stable(cnt)); // R7
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (pop_ok && !push_ok) |=> (cnt == $past(cnt) - 1'b1)); // R8
endmodule

// File: rtl/dual_cic_packer.sv
module dual_cic_packer
  import cicpack_pkg::*;
#(
  parameter int P_SMP_W  = SMP_W,
  parameter int P_RES_W  = RES_W,
  parameter int P_MAXL2  = MAX_LOG2R,
  parameter int P_DEPTH  = FIFO_DEPTH,
  parameter int P_CFG_W  = CFG_W,
  parameter int P_LVL_W  = LVL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [P_CFG_W-1:0]   cfg_log2r,
  input  logic                 cfg_vector,
  input  logic [P_LVL_W-1:0]   wm_level,
  input  logic                 ch0_valid,
  input  logic [P_SMP_W-1:0]   ch0_data,
  input  logic                 ch1_valid,
  input  logic [P_SMP_W-1:0]   ch1_data,
  output logic                 f0_dma_req,
  input  logic                 f0_dma_ack,
  output logic [2*P_RES_W-1:0] f0_rdata,
  output logic                 f0_irq,
  output logic                 f1_dma_req,
  input  logic                 f1_dma_ack,
  output logic [2*P_RES_W-1:0] f1_rdata,
  output logic                 f1_irq
);
  localparam int NCH = 2;
  localparam int WW  = 2 * P_RES_W;

  logic [P_CFG_W-1:0] cfg_q;
  store_mode_e        mode_q;
  logic               clr;
  logic               in_v   [NCH];
  logic [P_SMP_W-1:0] in_d   [NCH];
  logic               res_v  [NCH];
  logic [P_RES_W-1:0] res_d  [NCH];
  logic               pend_v [NCH];
  logic [P_RES_W-1:0] pend_d [NCH];
  logic               hold_v [NCH];
  logic [P_RES_W-1:0] hold_d [NCH];
  logic               pair_ready;
  logic               push   [NCH];
  logic [WW-1:0]      push_d [NCH];
  logic               ack    [NCH];
  logic               req    [NCH];
  logic [WW-1:0]      rdat   [NCH];
  logic               irq    [NCH];

  assign clr = (cfg_log2r != cfg_q) || (cfg_vector != logic'(mode_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      mode_q <= STORE_SPLIT;
    end else begin
      cfg_q  <= cfg_log2r;
      mode_q <= store_mode_e'(cfg_vector);
    end
  end

  assign in_v[0] = ch0_valid;  assign in_d[0] = ch0_data;
  assign in_v[1] = ch1_valid;  assign in_d[1] = ch1_data;
  assign ack[0]  = f0_dma_ack; assign ack[1]  = f1_dma_ack;

  assign pair_ready = hold_v[0] && hold_v[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cic3_decim #(.SMP_W(P_SMP_W), .RES_W(P_RES_W), .MAX_LOG2R(P_MAXL2), .CFG_W(P_CFG_W)) u_cic (
      .clk(clk), .rst_n(rst_n), .clr(clr), .log2r(cfg_q),
      .smp_valid(in_v[c]), .smp_data(in_d[c]),
      .res_valid(res_v[c]), .res_data(res_d[c]));

    assign hold_v[c] = res_v[c] || pend_v[c];
    assign hold_d[c] = res_v[c] ? res_d[c] : pend_d[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_v[c] <= 1'b0;
        pend_d[c] <= '0;
      end else if (clr || mode_q == STORE_SPLIT || pair_ready) begin
        pend_v[c] <= 1'b0;
      end else begin
        pend_v[c] <= hold_v[c];
        pend_d[c] <= hold_d[c];
      end
    end

    wm_fifo #(.W(WW), .DEPTH(P_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(push[c]), .push_data(push_d[c]), .ack(ack[c]), .wm(wm_level),
      .req(req[c]), .rd_data(rdat[c]), .irq(irq[c]));
  end

  always_comb begin
    if (mode_q == STORE_VECTOR) begin
      push[0]   = pair_ready;
      push_d[0] = {hold_d[1], hold_d[0]};
      push[1]   = 1'b0;
      push_d[1] = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        push[c]   = res_v[c];
        push_d[c] = {{P_RES_W{res_d[c][P_RES_W-1]}}, res_d[c]};
      end
    end
  end

  assign f0_dma_req = req[0];  assign f0_rdata = rdat[0];  assign f0_irq = irq[0];
  assign f1_dma_req = req[1];  assign f1_rdata = rdat[1];  assign f1_irq = irq[1];

  AST_VECTOR_FIFO1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == STORE_VECTOR && !clr) |=> $stable(f1_dma_req) || $fell(f1_dma_req)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!f0_dma_req && !f1_dma_req)); // R10
endmodule

// File: tb/test_dual_cic_packer.sv
module test_dual_cic_packer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_log2r = 3'd2;
  logic        cfg_vector = 1'b0;
  logic [5:0]  wm_level = 6'd4;
  logic        ch0_valid = 1'b0, ch1_valid = 1'b0;
  logic [9:0]  ch0_data = '0, ch1_data = '0;
  logic        f0_dma_ack = 1'b0, f1_dma_ack = 1'b0;
  logic        f0_dma_req, f1_dma_req, f0_irq, f1_irq;
  logic [31:0] f0_rdata, f1_rdata;

  dual_cic_packer i_dual_cic_packer (
    .clk(clk), .rst_n(rst_n), .cfg_log2r(cfg_log2r), .cfg_vector(cfg_vector),
    .wm_level(wm_level), .ch0_valid(ch0_valid), .ch0_data(ch0_data),
    .ch1_valid(ch1_valid), .ch1_data(ch1_data),
    .f0_dma_req(f0_dma_req), .f0_dma_ack(f0_dma_ack), .f0_rdata(f0_rdata), .f0_irq(f0_irq),
    .f1_dma_req(f1_dma_req), .f1_dma_ack(f1_dma_ack), .f1_rdata(f1_rdata), .f1_irq(f1_irq));

  always #10 clk = ~clk;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    started = 0, done = 0;
  string cur = "R11";
  int unsigned seed = 32'h1234_5678;

  // reference model state
  int          hist [2][$];
  int          phase [2];
  bit          rv [2], pv [2];
  int          rd [2], pd [2];
  logic [31:0] fq [2][$];
  int          ms;
  bit          mv;

  function automatic int hcoef(int r, int j);
    int n = 0;
    for (int a = 0; a < r; a++)
      for (int b = 0; b < r; b++) begin
        int c = j - a - b;
        if (c >= 0 && c < r) n++;
      end
    return n;
  endfunction

  function automatic int eff_of(int s);
    return (s > 4) ? 4 : s;
  endfunction

  function automatic int ref_result(int ch);
    int  e = eff_of(ms);
    int  r = 1 << e;
    int  n = hist[ch].size() - 1;
    longint y = 0;
    for (int j = 0; j <= 3 * r - 3; j++)
      if (n - j >= 0) y += longint'(hcoef(r, j)) * hist[ch][n - j];
    y = ((y <<< (3 * (4 - e))) + 32) >>> 6;
    return int'(y & 64'hFFFF);
  endfunction

  function automatic logic [31:0] sext16(int v);
    logic [15:0] h = v[15:0];
    return {{16{h[15]}}, h};
  endfunction

  task automatic model_clear();
    for (int c = 0; c < 2; c++) begin
      hist[c].delete(); fq[c].delete();
      phase[c] = 0; rv[c] = 0; pv[c] = 0; rd[c] = 0; pd[c] = 0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (!rst_n) begin
      model_clear(); ms = 0; mv = 0;
    end else if (cfg_log2r != ms[2:0] || cfg_vector != mv) begin
      model_clear(); ms = int'(cfg_log2r); mv = cfg_vector;
    end else begin
      bit h0, h1, full0, full1;
      int dd0, dd1;
      bit v [2];
      int dv [2];
      h0 = rv[0] || pv[0]; h1 = rv[1] || pv[1];
      dd0 = rv[0] ? rd[0] : pd[0]; dd1 = rv[1] ? rd[1] : pd[1];
      full0 = fq[0].size() == 32; full1 = fq[1].size() == 32;
      if (f0_dma_ack && fq[0].size() > 0) void'(fq[0].pop_front());
      if (f1_dma_ack && fq[1].size() > 0) void'(fq[1].pop_front());
      if (mv) begin
        if (h0 && h1) begin
          if (!full0) fq[0].push_back({dd1[15:0], dd0[15:0]});
          pv[0] = 0; pv[1] = 0;
        end else begin
          pv[0] = h0; pd[0] = dd0; pv[1] = h1; pd[1] = dd1;
        end
      end else begin
        pv[0] = 0; pv[1] = 0;
        if (rv[0] && !full0) fq[0].push_back(sext16(rd[0]));
        if (rv[1] && !full1) fq[1].push_back(sext16(rd[1]));
      end
      v[0] = ch0_valid; v[1] = ch1_valid;
      dv[0] = int'($signed(ch0_data)); dv[1] = int'($signed(ch1_data));
      for (int c = 0; c < 2; c++) begin
        rv[c] = 0;
        if (v[c]) begin
          hist[c].push_back(dv[c]);
          if (phase[c] == (1 << eff_of(ms)) - 1) begin
            rd[c] = ref_result(c); rv[c] = 1; phase[c] = 0;
          end else phase[c]++;
        end
      end
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", cur, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      bit e0, e1;
      e0 = fq[0].size() > 0; e1 = fq[1].size() > 0;
      check("f0_dma_req", 32'(f0_dma_req), 32'(e0));
      check("f1_dma_req", 32'(f1_dma_req), 32'(e1));
      if (e0) check("f0_rdata", f0_rdata, fq[0][0]);
      if (e1) check("f1_rdata", f1_rdata, fq[1][0]);
      check("f0_irq", 32'(f0_irq), 32'(wm_level != 0 && fq[0].size() >= int'(wm_level)));
      check("f1_irq", 32'(f1_irq), 32'(wm_level != 0 && fq[1].size() >= int'(wm_level)));
    end
  end

  function automatic logic [9:0] pick(int pat, int i);
    seed = seed * 32'd1103515245 + 32'd12345;
    case (pat)
      1: return 10'h1FF;
      2: return 10'h200;
      3: return (i % 2 == 0) ? 10'h1FF : 10'h200;
      default: return seed[25:16];
    endcase
  endfunction

  // per0/per1: sample period (0 = none); ackp: ack period (0 = none)
  task automatic run(int n, int pat, int per0, int per1, int ackp);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      ch0_valid  = (per0 != 0) && (i % per0 == 0);
      ch1_valid  = (per1 != 0) && (i % per1 == 0);
      ch0_data   = pick(pat, i);
      ch1_data   = pick(pat, i + 1);
      f0_dma_ack = (ackp != 0) && (i % ackp == 0);
      f1_dma_ack = (ackp != 0) && (i % ackp == 1 % ackp);
    end
  endtask

  task automatic set_cfg(int s, bit v);
    @(posedge clk); #2;
    cfg_log2r = 3'(s); cfg_vector = v;
    ch0_valid = 1'b1; ch1_valid = 1'b1; // samples of the flush cycle are discarded (R10)
    f0_dma_ack = 1'b0; f1_dma_ack = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    cur = "R11";  run(4, 0, 0, 0, 0);
    cur = "R1 R4 split ratio 4";      run(200, 0, 1, 1, 2);
    cur = "R8 uneven rates drain";    run(120, 0, 1, 3, 1);
    run(40, 0, 0, 0, 1);
    cur = "R8 ack on empty";          run(10, 0, 0, 0, 1);
    cur = "R10 ratio change";         set_cfg(4, 0);
    cur = "R2 positive full scale";   run(120, 1, 1, 1, 1);
    cur = "R2 negative full scale";   run(120, 2, 1, 1, 1);
    cur = "R2 alternating";           run(120, 3, 1, 1, 1);
    cur = "R3 ratio clamp";           set_cfg(7, 0); run(200, 0, 1, 1, 1);
    cur = "R1 ratio one";             set_cfg(0, 0); run(60, 0, 1, 2, 1);
    cur = "R5 vector pack";           set_cfg(1, 1); run(120, 0, 1, 1, 1);
    cur = "R6 vector uneven";         run(150, 0, 1, 2, 1);
    run(150, 0, 3, 1, 1);
    cur = "R7 R9 fill past depth";    set_cfg(0, 0);
    wm_level = 6'd8;                  run(60, 0, 1, 1, 0);
    cur = "R8 drain";                 run(40, 0, 0, 0, 1);
    cur = "R10 mode change flush";    run(20, 0, 1, 1, 0);
    set_cfg(0, 1);                    run(10, 0, 0, 0, 0);
    cur = "R9 watermark off";         set_cfg(0, 0);
    wm_level = 6'd0;                  run(40, 0, 1, 1, 0);
    cur = "R9 watermark full";        wm_level = 6'd32; run(10, 0, 1, 1, 0);
    finish_run();
  end
endmodule